// File: doc/BRIEF.md
# Tap-Select Programmable Timer and Divider

This block is a synchronous timer that counts rising edges of a count input inside one system clock domain. A 16-stage binary counter advances once per qualifying edge. A two-bit select code picks one counter stage as the tap that drives the timer output, so the output divides the edge rate by 2^n with n set by the select code.

Two modes share the counter. With the mode input high, the block is a free-running divider and the output is a square wave that toggles every 2^(n-1) edges. With the mode input low, it is a single-transition timer: the output flips once, 2^(n-1) edges after a restart, and then holds that level until the latch is released. A phase input sets the resting polarity of the output. A clear input, and an internally generated power-up clear pulse that a disable input can suppress, return the count and the latch to their start state.

Top module: `tap_timer`

## Requirements
- R1: The counter advances by exactly one on each low-to-high transition of `cnt_in` as sampled on `clk`. A level held high for several clocks counts once.
- R2: The select code `sel` picks the tap stage n: 2'b00 gives 13, 2'b01 gives 10, 2'b10 gives 8, 2'b11 gives 16.
- R3: With `run_mode` high, `tmr_out` equals `phase` XOR counter bit n-1, so it toggles every 2^(n-1) edges.
- R4: With `run_mode` low, `tmr_out` leaves the `phase` level once the count reaches 2^(n-1) and stays at the inverted level afterwards, even after the tapped bit falls again.
- R5: While `hard_clr` is high, the counter is held at zero, count edges are ignored, the single-shot latch is cleared and `tmr_out` follows `phase`.
- R6: After any clear, `tmr_out` rests at the `phase` level: low for `phase` = 0, high for `phase` = 1.
- R7: A low-to-high transition of `run_mode` clears the single-shot latch and restarts the count from zero.
- R8: After `rst_n` is released with `por_off` low, an internal clear lasting `POR_CYCLES` clocks (default 4) acts exactly like `hard_clr`. With `por_off` high, no internal clear occurs.
- R9: A change of `sel` takes effect on the next count edge and does not clear the count.
- R10: `tmr_out` is registered: it changes in the clock after the clock that registers the qualifying count edge.
- R11: During and immediately after `rst_n` low, the count is zero and `tmr_out` equals `phase`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cnt_in | input | 1 | Count input. Its rising edges advance the counter |
| sel | input | 2 | Tap select code (see R2) |
| run_mode | input | 1 | 1 = free-running divider, 0 = single-transition timer |
| phase | input | 1 | Output polarity at rest after a clear |
| hard_clr | input | 1 | Active-high clear of count and latch |
| por_off | input | 1 | High disables the internal power-up clear |
| tmr_out | output | 1 | Timer output |

## Verification
The hardest state to reach is the single-shot latch on the 16-stage tap, because it needs 32768 count edges. The bench drives each edge as a one-clock high pulse so the long run fits the cycle budget. The latch must also be shown to hold after its tapped bit has fallen again, which needs a count past 2^n on a short tap. The power-up clear window is reached by releasing `rst_n` with `por_off` low and issuing edges at once, so that the first two edges land inside the window and are swallowed.

// File: rtl/tap_timer_pkg.sv
// Package: shared constants and the tap lookup for the tap-select timer.
// Assumes every stage count returned is at most the counter width in use.
package tap_timer_pkg;

    localparam int unsigned STAGE_C0 = 13;
    localparam int unsigned STAGE_C1 = 10;
    localparam int unsigned STAGE_C2 = 8;
    localparam int unsigned STAGE_C3 = 16;

    // Map a select code to the number of counter stages used.
    function automatic int unsigned tap_stage(input logic [1:0] code);
        case (code)
            2'b00:   return STAGE_C0;
            2'b01:   return STAGE_C1;
            2'b10:   return STAGE_C2;
            default: return STAGE_C3;
        endcase
    endfunction

endpackage

// File: rtl/tap_timer_edge.sv
// Rising-edge detector for a level that is already synchronous to clk.
// The flop tracks the level during reset, so a level that is high at
// release does not count as an edge.
module tap_timer_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic prev_q;

    // Hold the previous sample of the level.
    always_ff @(posedge clk) begin
        prev_q <= level;
    end

    assign rise = level & ~prev_q & rst_n;

endmodule

// File: rtl/tap_timer_por.sv
// Power-up clear generator: a pulse of CYCLES clocks after rst_n is
// released, masked whenever the disable input is high.
module tap_timer_por #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic disable_req,
    output logic pulse
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    // Count the remaining clocks of the window down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= CW'(CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    assign pulse = (left_q != '0) && !disable_req;

endmodule

// File: rtl/tap_timer_count.sv
// Binary edge counter with a tap register. The tap position is loaded
// from the select code on reset, on clear and on every count step, so a
// new code applies at the next count edge without disturbing the count.
module tap_timer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] cnt_val,
    output logic             tap_bit
);

    import tap_timer_pkg::*;

    localparam int IDX_W = $clog2(CNT_W);

    logic [IDX_W-1:0] pos_q;
    logic [IDX_W-1:0] pos_new;

    assign pos_new = IDX_W'(tap_stage(sel) - 1);

    // Advance, clear or hold the count and the tap position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_val <= '0;
            pos_q   <= pos_new;
        end else if (step) begin
            cnt_val <= cnt_val + CNT_W'(1);
            pos_q   <= pos_new;
        end
    end

    assign tap_bit = cnt_val[pos_q];

endmodule

// File: rtl/tap_timer.sv
// Tap-select timer top: counts rising edges of cnt_in, drives tmr_out
// from the selected stage either as a divider or as a one-shot latch.
// Assumes all inputs are synchronous to clk.
module tap_timer #(
    parameter int CNT_W      = 16,
    parameter int POR_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_in,
    input  logic [1:0] sel,
    input  logic       run_mode,
    input  logic       phase,
    input  logic       hard_clr,
    input  logic       por_off,
    output logic       tmr_out
);

    logic             cnt_rise;
    logic             mode_rise;
    logic             por_pulse;
    logic             clr_act;
    logic             restart;
    logic [CNT_W-1:0] cnt_val;
    logic             tap_bit;
    logic             latch_q;
    logic             hit;
    logic             out_q;

    tap_timer_edge u_cnt_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (cnt_in),
        .rise  (cnt_rise)
    );

    tap_timer_edge u_mode_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (run_mode),
        .rise  (mode_rise)
    );

    tap_timer_por #(.CYCLES(POR_CYCLES)) u_por (
        .clk         (clk),
        .rst_n       (rst_n),
        .disable_req (por_off),
        .pulse       (por_pulse)
    );

    assign clr_act = hard_clr | por_pulse;
    assign restart = clr_act | mode_rise;

    tap_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .step    (cnt_rise),
        .sel     (sel),
        .cnt_val (cnt_val),
        .tap_bit (tap_bit)
    );

    assign hit = latch_q | tap_bit;

    // Keep the one-shot latch and the registered output.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            latch_q <= 1'b0;
            out_q   <= phase;
        end else begin
            latch_q <= latch_q | (tap_bit & ~run_mode);
            out_q   <= phase ^ (run_mode ? tap_bit : hit);
        end
    end

    assign tmr_out = out_q;

endmodule

// File: rtl/tap_timer_chk.sv
// Checker for tap_timer: temporal properties on ports and internal nets,
// attached to every tap_timer instance through bind.
module tap_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hard_clr,
    input logic             por_off,
    input logic             phase,
    input logic             tmr_out,
    input logic             cnt_rise,
    input logic             mode_rise,
    input logic             por_pulse,
    input logic [CNT_W-1:0] cnt_val,
    input logic             latch_q
);

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rise && !hard_clr && !por_pulse && !mode_rise)
        |=> cnt_val == CNT_W'($past(cnt_val) + CNT_W'(1)));

    // R1
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_rise && !hard_clr && !por_pulse && !mode_rise)
        |=> $stable(cnt_val));

    // R5
    clr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> (tmr_out == $past(phase)) && (cnt_val == '0));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !hard_clr && !por_pulse && !mode_rise) |=> latch_q);

    // R7
    mode_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rise |=> (cnt_val == '0) && !latch_q);

    // R8
    por_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_pulse |-> !por_off);

endmodule

bind tap_timer tap_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hard_clr  (hard_clr),
    .por_off   (por_off),
    .phase     (phase),
    .tmr_out   (tmr_out),
    .cnt_rise  (cnt_rise),
    .mode_rise (mode_rise),
    .por_pulse (por_pulse),
    .cnt_val   (cnt_val),
    .latch_q   (latch_q)
);

// File: tb/tap_timer_tb_top.sv
// Self-checking bench for tap_timer: a vector table walked by one loop,
// then directed tests for reset, clears, restarts and timing.
module tap_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_in = 1'b0;
    logic [1:0] sel = 2'b10;
    logic       run_mode = 1'b1;
    logic       phase = 1'b0;
    logic       hard_clr = 1'b0;
    logic       por_off = 1'b1;
    logic       tmr_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    tap_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_in   (cnt_in),
        .sel      (sel),
        .run_mode (run_mode),
        .phase    (phase),
        .hard_clr (hard_clr),
        .por_off  (por_off),
        .tmr_out  (tmr_out)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic        mode;
        logic        ph;
        logic [16:0] edges;
        logic        exp;
    } vec_t;

    // Codes: 00->13, 01->10, 10->8, 11->16 stages.
    localparam vec_t VECS [11] = '{
        '{2'b10, 1'b1, 1'b0, 17'd127,   1'b0},
        '{2'b10, 1'b1, 1'b0, 17'd128,   1'b1},
        '{2'b10, 1'b1, 1'b0, 17'd256,   1'b0},
        '{2'b10, 1'b1, 1'b1, 17'd128,   1'b0},
        '{2'b01, 1'b1, 1'b0, 17'd511,   1'b0},
        '{2'b01, 1'b1, 1'b0, 17'd512,   1'b1},
        '{2'b00, 1'b0, 1'b0, 17'd4095,  1'b0},
        '{2'b00, 1'b0, 1'b0, 17'd4096,  1'b1},
        '{2'b10, 1'b0, 1'b0, 17'd300,   1'b1},
        '{2'b10, 1'b0, 1'b1, 17'd266,   1'b0},
        '{2'b11, 1'b0, 1'b0, 17'd32768, 1'b1}
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: tmr_out=%0b expected %0b", req, act, exp);
        end
    endtask

    // Drive n edges, each high for hi clocks and low for one; end on the
    // negedge after the output register has taken the last edge.
    task automatic edges(input int n, input int hi);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) cnt_in = 1'b1;
            repeat (hi - 1) @(negedge clk);
            @(negedge clk) cnt_in = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic clear_run(input logic [1:0] s, input logic m, input logic p);
        @(negedge clk);
        sel = s; run_mode = m; phase = p; hard_clr = 1'b1;
        @(negedge clk) hard_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(tmr_out, 1'b0, "R11");

        // R2 R3 R4 R6: table of tap, mode, phase and edge counts
        foreach (VECS[k]) begin
            clear_run(VECS[k].sel, VECS[k].mode, VECS[k].ph);
            edges(int'(VECS[k].edges), 1);
            check(tmr_out, VECS[k].exp, $sformatf("R2/R3/R4/R6 vec%0d", k));
        end

        // R1: long high levels count once each
        clear_run(2'b10, 1'b1, 1'b0);
        edges(127, 3);
        check(tmr_out, 1'b0, "R1 127 long pulses");
        edges(1, 3);
        check(tmr_out, 1'b1, "R1 128 long pulses");

        // R5: clear held, edges ignored, output follows phase
        clear_run(2'b10, 1'b1, 1'b0);
        @(negedge clk) hard_clr = 1'b1;
        edges(200, 1);
        check(tmr_out, 1'b0, "R5 held clear");
        phase = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(tmr_out, 1'b1, "R5 follows phase");
        phase = 1'b0;
        @(negedge clk) hard_clr = 1'b0;
        edges(128, 1);
        check(tmr_out, 1'b1, "R5 count from zero");

        // R7: mode rise releases latch and restarts count
        clear_run(2'b10, 1'b0, 1'b0);
        edges(128, 1);
        check(tmr_out, 1'b1, "R7 latch set");
        run_mode = 1'b1;
        @(negedge clk);
        check(tmr_out, 1'b0, "R7 latch released");
        edges(127, 1);
        check(tmr_out, 1'b0, "R7 restart 127");
        edges(1, 1);
        check(tmr_out, 1'b1, "R7 restart 128");

        // R9: tap change waits for a count edge and keeps the count
        clear_run(2'b10, 1'b1, 1'b0);
        edges(130, 1);
        check(tmr_out, 1'b1, "R9 before change");
        sel = 2'b01;
        repeat (3) @(negedge clk);
        check(tmr_out, 1'b1, "R9 no edge yet");
        edges(1, 1);
        check(tmr_out, 1'b0, "R9 new tap");
        edges(381, 1);
        check(tmr_out, 1'b1, "R9 count kept");

        // R10: output one clock after the registered edge
        clear_run(2'b10, 1'b1, 1'b0);
        edges(127, 1);
        @(negedge clk) cnt_in = 1'b1;
        @(negedge clk);
        check(tmr_out, 1'b0, "R10 edge clock");
        cnt_in = 1'b0;
        @(negedge clk);
        check(tmr_out, 1'b1, "R10 next clock");

        // R8: power-up clear swallows the first two edges
        sel = 2'b10; run_mode = 1'b1; phase = 1'b0; por_off = 1'b0;
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        edges(128, 1);
        check(tmr_out, 1'b0, "R8 window swallows");
        edges(2, 1);
        check(tmr_out, 1'b1, "R8 after window");

        // R8: disabled power-up clear
        por_off = 1'b1;
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        edges(128, 1);
        check(tmr_out, 1'b1, "R8 disabled");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule